// File: doc/BRIEF.md
# I2C Status Flags and Clock-Stretch Control

This block holds the event and status flags of an I2C controller that can work as bus master or as slave. It shows them to software as one 8-bit status word. The serial engine reports single-cycle event strobes to the block: byte finished, STOP observed, addressed as a slave, arbitration lost, ACK sampled, and general call or address acknowledged. It also supplies the bus-busy and transmit-direction levels. The block returns an interrupt request to the system. It also returns a request to the engine to keep SCL driven low.

Software answers an interrupt with one write of any value to the status word. That write releases the stretched clock and clears the clearable event flags. Bit 7 means one thing in master mode and another in slave mode. As a master it records that the addressed slave acknowledged. As a slave it records that the general call address was seen. Software cannot write bit 7. The engine clears it, either with a STOP or with a dedicated clear strobe. If an event and a software write land in the same cycle, the event always wins, so no event is lost.

Top module: `i2c_stat_hold`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `status_o` is 0x00 and both `irq_o` and `scl_hold_o` are 0.
- R2: Each event strobe sets its own bit of `status_o` from the next cycle on. The mapping is: byte done to bit 6, STOP seen to bit 5, addressed as slave to bit 4, arbitration lost to bit 3. The bit stays set until it is cleared.
- R3: A cycle with `wr_i` = 1 clears bits 6, 5, 4, 3 and 0 at the next cycle, except where an event for that bit arrives in the same cycle.
- R4: When `ack_stb_i` is 1, bit 0 takes the value of `ack_lvl_i` at the next cycle (1 means an ACK was received).
- R5: Bit 7 sets one cycle after `top_evt_i`. It clears one cycle after `stop_seen_i` or `top_clr_i` when no set arrives in the same cycle. A write has no effect on it.
- R6: Bit 2 follows `bus_busy_i` one cycle later and bit 1 follows `tx_mode_i` one cycle later. A write has no effect on either bit.
- R7: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one of bits 7, 6, 5, 4, 3 or 0 is set.
- R8: When `irq_en_i` is 1 and a clock-stretching event arrives, `scl_hold_o` is 1 from the next cycle on. The clock-stretching events are byte done, addressed, arbitration lost, `top_evt_i`, and `ack_stb_i` with `ack_lvl_i` = 1.
- R9: A STOP strobe with no other stretching event never raises `scl_hold_o`.
- R10: A write drops `scl_hold_o` at the next cycle if no stretching event arrives in the same cycle.
- R11: When a write and an event share a cycle, the event wins. Its flag ends up set, and a stretching event keeps `scl_hold_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done_i | input | 1 | Strobe: one byte fully transferred |
| stop_seen_i | input | 1 | Strobe: STOP condition observed |
| addressed_i | input | 1 | Strobe: addressed as slave by another master |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| ack_stb_i | input | 1 | Strobe: ACK sampled in ninth SCL period |
| ack_lvl_i | input | 1 | Sampled ACK result, 1 = acknowledged |
| top_evt_i | input | 1 | Strobe: address ACK (master) or general call (slave) |
| top_clr_i | input | 1 | Engine clear of bit 7 |
| bus_busy_i | input | 1 | Bus busy level |
| tx_mode_i | input | 1 | 1 = transmitting, 0 = receiving |
| irq_en_i | input | 1 | Interrupt enable |
| wr_i | input | 1 | CPU write to the status word (data ignored) |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Hold SCL low request |

## Verification
The hardest case to reach is a software write that lands in the same cycle as an event. In that case the event must win for both the flag and the clock hold. The case also covers bit 7, which must survive the write while the other flags clear. Directed sequences first set several flags and a hold, then pair a write with each strobe in turn. Random traffic with frequent writes and strobes then produces many further overlaps, including STOP-only cycles with the interrupt enabled.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int B_TOP   = 7;
  localparam int B_TEND  = 6;
  localparam int B_STOP  = 5;
  localparam int B_SSEL  = 4;
  localparam int B_MLOST = 3;
  localparam int B_BUSY  = 2;
  localparam int B_TMODE = 1;
  localparam int B_RACK  = 0;
  localparam int N_SIMPLE = 4;
  localparam int N_IRQ_SRC = 6;
endpackage

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic q, q_nxt, q_en;

  always_comb begin
    q_en  = set_i | clr_i;
    q_nxt = set_i & (SET_WINS | ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end

  assign flag_o = q;

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  a_r2_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));

  if (SET_WINS) begin : g_set_wins
    a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
  end
endmodule

// File: rtl/i2c_ack_capture.sv
module i2c_ack_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic rack_o
);
  logic q, q_nxt, q_en;

  always_comb begin
    q_en  = stb_i | clr_i;
    q_nxt = stb_i ? lvl_i : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end

  assign rack_o = q;

  a_r4_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> (rack_o == $past(lvl_i)));
  a_r3_ack_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !stb_i) |=> !rack_o);
endmodule

// File: rtl/i2c_hold_ctl.sv
module i2c_hold_ctl
  import i2c_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IRQ_SRC-1:0] src_i,
  input  logic                 stretch_evt_i,
  input  logic                 stop_evt_i,
  input  logic                 irq_en_i,
  input  logic                 wr_i,
  output logic                 irq_o,
  output logic                 hold_o
);
  logic hold_set;

  always_comb begin
    hold_set = irq_en_i & stretch_evt_i;
    irq_o    = irq_en_i & (|src_i);
  end

  i2c_sticky_flag #(.SET_WINS(1'b1)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hold_set),
    .clr_i (wr_i),
    .flag_o(hold_o)
  );

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i);
  a_r8_hold_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i && stretch_evt_i) |=> hold_o);
  a_r9_stop_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt_i && !stretch_evt_i && !hold_o) |=> !hold_o);
  a_r10_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(irq_en_i && stretch_evt_i)) |=> !hold_o);
endmodule

// File: rtl/i2c_stat_hold.sv
module i2c_stat_hold
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done_i,
  input  logic              stop_seen_i,
  input  logic              addressed_i,
  input  logic              arb_lost_i,
  input  logic              ack_stb_i,
  input  logic              ack_lvl_i,
  input  logic              top_evt_i,
  input  logic              top_clr_i,
  input  logic              bus_busy_i,
  input  logic              tx_mode_i,
  input  logic              irq_en_i,
  input  logic              wr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              scl_hold_o
);
  localparam int SIMPLE_POS [N_SIMPLE] = '{B_TEND, B_STOP, B_SSEL, B_MLOST};

  logic [N_SIMPLE-1:0] simple_set;
  logic [N_SIMPLE-1:0] simple_q;
  logic                top_q, top_clr, rack_q;
  logic                busy_q, tmode_q, busy_nxt, tmode_nxt;
  logic                stretch_evt;
  logic [N_IRQ_SRC-1:0] irq_src;
  logic [STAT_W-1:0]   stat;

  always_comb begin
    simple_set  = {arb_lost_i, addressed_i, stop_seen_i, byte_done_i};
    top_clr     = stop_seen_i | top_clr_i;
    stretch_evt = byte_done_i | addressed_i | arb_lost_i | top_evt_i
                | (ack_stb_i & ack_lvl_i);
    busy_nxt    = bus_busy_i;
    tmode_nxt   = tx_mode_i;
  end

  for (genvar g = 0; g < N_SIMPLE; g++) begin : g_flag
    i2c_sticky_flag #(.SET_WINS(1'b1)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (simple_set[g]),
      .clr_i (wr_i),
      .flag_o(simple_q[g])
    );
  end

  i2c_sticky_flag #(.SET_WINS(1'b1)) u_top (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (top_evt_i),
    .clr_i (top_clr),
    .flag_o(top_q)
  );

  i2c_ack_capture u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (ack_stb_i),
    .lvl_i (ack_lvl_i),
    .clr_i (wr_i),
    .rack_o(rack_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tmode_q <= 1'b0;
    end else begin
      busy_q  <= busy_nxt;
      tmode_q <= tmode_nxt;
    end
  end

  always_comb begin
    stat = '0;
    for (int i = 0; i < N_SIMPLE; i++) stat[SIMPLE_POS[i]] = simple_q[i];
    stat[B_TOP]   = top_q;
    stat[B_BUSY]  = busy_q;
    stat[B_TMODE] = tmode_q;
    stat[B_RACK]  = rack_q;
    irq_src = {top_q, simple_q, rack_q};
  end

  assign status_o = stat;

  i2c_hold_ctl u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (irq_src),
    .stretch_evt_i(stretch_evt),
    .stop_evt_i   (stop_seen_i),
    .irq_en_i     (irq_en_i),
    .wr_i         (wr_i),
    .irq_o        (irq_o),
    .hold_o       (scl_hold_o)
  );

  a_r5_top_sets: assert property (@(posedge clk) disable iff (!rst_n)
    top_evt_i |=> status_o[B_TOP]);
  a_r5_top_write_immune: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !top_clr && !top_evt_i) |=> $stable(status_o[B_TOP]));
  a_r6_levels_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[B_BUSY] == $past(bus_busy_i))
          && (status_o[B_TMODE] == $past(tx_mode_i)));
  a_r2_tend_sets: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_i |=> status_o[B_TEND]);
endmodule

// File: tb/test_i2c_stat_hold.sv
module test_i2c_stat_hold;
  logic clk = 1'b0;
  logic rst_n;
  logic byte_done, stop_seen, addressed, arb_lost, ack_stb, ack_lvl;
  logic top_evt, top_clr, bus_busy, tx_mode, irq_en, wr;
  logic [7:0] status;
  logic irq, hold;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic m_top, m_tend, m_stopd, m_ssel, m_mlost, m_busy, m_tmode, m_rack, m_hold;

  always #10 clk = ~clk;

  i2c_stat_hold i_i2c_stat_hold (
    .clk(clk), .rst_n(rst_n),
    .byte_done_i(byte_done), .stop_seen_i(stop_seen), .addressed_i(addressed),
    .arb_lost_i(arb_lost), .ack_stb_i(ack_stb), .ack_lvl_i(ack_lvl),
    .top_evt_i(top_evt), .top_clr_i(top_clr), .bus_busy_i(bus_busy),
    .tx_mode_i(tx_mode), .irq_en_i(irq_en), .wr_i(wr),
    .status_o(status), .irq_o(irq), .scl_hold_o(hold)
  );

  function automatic bit chance(int unsigned n);
    return ($urandom % n) == 0;
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_top, m_tend, m_stopd, m_ssel, m_mlost, m_busy, m_tmode, m_rack};
  endfunction

  function automatic logic exp_irq();
    return irq_en & (m_top | m_tend | m_stopd | m_ssel | m_mlost | m_rack);
  endfunction

  task automatic cmp(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_status();
    cmp("R5 bit7", status[7], e[7]);
    cmp("R2 R3 R11 bit6", status[6], e[6]);
    cmp("R2 R3 R11 bit5", status[5], e[5]);
    cmp("R2 R3 R11 bit4", status[4], e[4]);
    cmp("R2 R3 R11 bit3", status[3], e[3]);
    cmp("R6 bit2", status[2], e[2]);
    cmp("R6 bit1", status[1], e[1]);
    cmp("R4 R3 bit0", status[0], e[0]);
    cmp("R7 irq", irq, exp_irq());
    cmp("R8 R9 R10 R11 hold", hold, m_hold);
  endtask

  task automatic model_step();
    logic stretch;
    stretch = byte_done | addressed | arb_lost | top_evt | (ack_stb & ack_lvl);
    m_tend  = byte_done ? 1'b1 : (wr ? 1'b0 : m_tend);
    m_stopd = stop_seen ? 1'b1 : (wr ? 1'b0 : m_stopd);
    m_ssel  = addressed ? 1'b1 : (wr ? 1'b0 : m_ssel);
    m_mlost = arb_lost  ? 1'b1 : (wr ? 1'b0 : m_mlost);
    m_rack  = ack_stb ? ack_lvl : (wr ? 1'b0 : m_rack);
    m_top   = top_evt ? 1'b1 : ((stop_seen | top_clr) ? 1'b0 : m_top);
    m_busy  = bus_busy;
    m_tmode = tx_mode;
    m_hold  = (irq_en & stretch) ? 1'b1 : (wr ? 1'b0 : m_hold);
  endtask

  task automatic quiet();
    byte_done = 0; stop_seen = 0; addressed = 0; arb_lost = 0;
    ack_stb = 0; ack_lvl = 0; top_evt = 0; top_clr = 0; wr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    check_all();
    @(negedge clk);
    quiet();
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    quiet();
    bus_busy = 1'b1; tx_mode = 1'b1; irq_en = 1'b1;
    {m_top, m_tend, m_stopd, m_ssel, m_mlost, m_busy, m_tmode, m_rack, m_hold} = '0;
    repeat (3) @(negedge clk);
    check_all();  // R1 reset state with levels high on inputs
    @(negedge clk);
    rst_n = 1'b1;
    bus_busy = 1'b0; tx_mode = 1'b0;
    tick();       // R1 first cycle after reset

    // R9: STOP alone with interrupts enabled does not hold SCL
    stop_seen = 1; tick();
    wr = 1; tick();

    // R2 R8: set flags, then R3 R10: write clears while R5 top survives
    byte_done = 1; top_evt = 1; tick();
    addressed = 1; arb_lost = 1; ack_stb = 1; ack_lvl = 1; tick();
    bus_busy = 1; tx_mode = 1; tick();
    wr = 1; tick();   // R6 levels unaffected, R5 bit7 kept
    top_clr = 1; tick();

    // R11: write colliding with each event in turn
    byte_done = 1; wr = 1; tick();
    wr = 1; tick();
    addressed = 1; wr = 1; tick();
    arb_lost = 1; wr = 1; tick();
    stop_seen = 1; wr = 1; tick();
    ack_stb = 1; ack_lvl = 1; wr = 1; tick();
    ack_stb = 1; ack_lvl = 0; wr = 1; tick();  // R4 nack loaded, hold released
    top_evt = 1; stop_seen = 1; tick();         // R5 set wins over stop clear

    // R8: events with interrupts disabled do not hold
    wr = 1; tick();
    irq_en = 0; byte_done = 1; tick();
    tick();
    irq_en = 1; tick();

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      byte_done = chance(7);
      stop_seen = chance(9);
      addressed = chance(11);
      arb_lost  = chance(13);
      ack_stb   = chance(6);
      ack_lvl   = chance(2);
      top_evt   = chance(12);
      top_clr   = chance(15);
      wr        = chance(4);
      if (chance(10)) bus_busy = ~bus_busy;
      if (chance(10)) tx_mode = ~tx_mode;
      if (chance(20)) irq_en = ~irq_en;
      tick();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at %0t: got hung expected finished", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule